// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit sits between the instruction decoder of a serial memory and its storage array. For every write the decoder presents, it decides whether the write may go ahead. Three sources can each block a write on their own: a software write-enable latch, a two-bit protected-region code, and a hardware write-protect pin.

The decoder sends single-cycle strobes for the enable, disable, status-write and array-write instructions, along with the chip-select level. The latch is set and cleared by the enable and disable strobes. It also clears itself when chip select goes high after a transaction that contained an array write or a status write. The region code lives in the status register. A status write may change it only when the latch is set and the protect pin is high. The protect pin guards only the region code; it has no say over array writes.

The unit also gives the full status byte for readback. That byte carries a busy flag, the latch and the region code.

Top module: `wprot_unit`

## Requirements
- R1: After a synchronous reset, the latch is 0, the region code is 00, `wr_allow` and `wr_deny` are 0, and `status` reads 8'h00 while `busy` is low.
- R2: An `op_wren` strobe sets the latch. The latch shows as `status[1]` after the next rising clock edge.
- R3: An `op_wrdi` strobe clears the latch at the next edge. When `op_wren` and `op_wrdi` arrive in the same cycle, `op_wrdi` wins.
- R4: Each `chk_valid` cycle gives exactly one of `wr_allow` or `wr_deny`, high for one cycle, one edge later. `wr_allow` requires the latch to be set in the `chk_valid` cycle.
- R5: The region code sits in `status[3:2]`. Code 00 protects nothing. Code 01 protects the upper quarter (addresses 0xC000 and up for 16 address bits). Code 10 protects the upper half (0x8000 and up). Code 11 protects every address. A check that hits a protected address is denied.
- R6: An `op_wrsr` strobe with the latch set and `wp_n` high loads `sr_wdata[3:2]` into the region code. The other data bits have no effect: `status[7:4]` stay 0, and bits 1:0 are not written.
- R7: An `op_wrsr` strobe with the latch clear, or with `wp_n` low, leaves the region code unchanged. `wp_n` low does not deny array writes.
- R8: The latch clears when `cs_n` rises at the end of a transaction that carried an `op_write` or `op_wrsr` strobe. A `cs_n` rise without such a strobe leaves the latch set.
- R9: `status[0]` follows `busy`, delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select level, low while a transaction is open |
| wp_n | input | 1 | Hardware protect pin, low locks the region code |
| busy | input | 1 | Store or recall in progress |
| op_wren | input | 1 | Write-enable instruction strobe |
| op_wrdi | input | 1 | Write-disable instruction strobe |
| op_wrsr | input | 1 | Status-write strobe, data in `sr_wdata` |
| op_write | input | 1 | Array-write instruction strobe |
| sr_wdata | input | 8 | Status byte to be written |
| chk_valid | input | 1 | Request for a write decision |
| chk_addr | input | ADDR_W | Array address to judge |
| wr_allow | output | 1 | Registered grant, one edge after `chk_valid` |
| wr_deny | output | 1 | Registered refusal, one edge after `chk_valid` |
| status | output | 8 | Status byte for readback |

## Verification
The bench builds the unit with the default `ADDR_W` of 16. This places the quarter and half boundaries at 0xC000 and 0x8000, so addresses on both sides of each boundary can be driven directly. A behavioural model compares against the unit on every clock, using numeric address thresholds rather than bit slices. Directed phases cover the boundaries, the lock from the protect pin, the priority of the disable strobe, and the clearing of the latch at chip-select rise. A randomized stretch then mixes all strobes and addresses.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int SR_W = 8;
  localparam int RDY_BIT = 0;
  localparam int WEL_BIT = 1;
  localparam int BP_LO   = 2;

  typedef enum logic [1:0] {
    REG_NONE    = 2'b00,
    REG_QUARTER = 2'b01,
    REG_HALF    = 2'b10,
    REG_ALL     = 2'b11
  } region_e;

  // top2 holds the two most significant address bits
  function automatic logic region_hit(input region_e r, input logic [1:0] top2);
    case (r)
      REG_NONE:    region_hit = 1'b0;
      REG_QUARTER: region_hit = (top2 == 2'b11);
      REG_HALF:    region_hit = top2[1];
      default:     region_hit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/wprot_latch.sv
module wprot_latch (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic op_wren,
  input  logic op_wrdi,
  input  logic op_wrsr,
  input  logic op_write,
  output logic wel
);
  logic cs_q, pend_q, wel_q;
  logic cs_rise;

  assign cs_rise = cs_n & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      pend_q <= 1'b0;
      wel_q  <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (cs_rise) pend_q <= 1'b0;
      else         pend_q <= pend_q | op_write | op_wrsr;
      if (op_wrdi)              wel_q <= 1'b0;
      else if (op_wren)         wel_q <= 1'b1;
      else if (cs_rise && pend_q) wel_q <= 1'b0;
    end
  end

  assign wel = wel_q;

  AST_WREN_SETS: assert property (@(posedge clk) disable iff (rst)
    (op_wren && !op_wrdi) |=> wel_q); // R2
  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    op_wrdi |=> !wel_q); // R3
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && pend_q && !op_wren) |=> !wel_q); // R8
endmodule

// File: rtl/wprot_stat.sv
module wprot_stat
  import wprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wp_n,
  input  logic       busy,
  input  logic       wel,
  input  logic       op_wrsr,
  input  logic [1:0] bp_wdata,
  output region_e    bp,
  output logic       rdy
);
  region_e bp_q;
  logic    busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q   <= REG_NONE;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy;
      if (op_wrsr && wel && wp_n) bp_q <= region_e'(bp_wdata);
    end
  end

  assign bp  = bp_q;
  assign rdy = busy_q;

  AST_PIN_LOCKS_BP: assert property (@(posedge clk) disable iff (rst)
    !wp_n |=> (bp_q == $past(bp_q))); // R7
  AST_NO_WEL_LOCKS_BP: assert property (@(posedge clk) disable iff (rst)
    !wel |=> (bp_q == $past(bp_q))); // R7
  AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (busy_q == $past(busy))); // R9
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              wel,
  input  region_e           bp,
  output logic              allow,
  output logic              deny
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] top2;
  logic       hit, ok;
  logic       unused_low;

  assign top2       = chk_addr[TOP -: 2];
  assign unused_low = ^chk_addr[TOP-2:0];
  assign hit        = region_hit(bp, top2);
  assign ok         = wel & ~hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      allow <= 1'b0;
      deny  <= 1'b0;
    end else begin
      allow <= chk_valid & ok;
      deny  <= chk_valid & ~ok;
    end
  end

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> (allow ^ deny)); // R4
  AST_NO_WEL_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    !wel |=> !allow); // R4
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (bp == REG_ALL) |=> !allow); // R5
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              op_wren,
  input  logic              op_wrdi,
  input  logic              op_wrsr,
  input  logic              op_write,
  input  logic [SR_W-1:0]   sr_wdata,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              wr_allow,
  output logic              wr_deny,
  output logic [SR_W-1:0]   status
);
  logic    wel, rdy;
  region_e bp;
  logic    unused_wdata;

  assign unused_wdata = ^{sr_wdata[SR_W-1:BP_LO+2], sr_wdata[BP_LO-1:0]};

  wprot_latch u_latch (
    .clk(clk), .rst(rst), .cs_n(cs_n),
    .op_wren(op_wren), .op_wrdi(op_wrdi),
    .op_wrsr(op_wrsr), .op_write(op_write),
    .wel(wel)
  );

  wprot_stat u_stat (
    .clk(clk), .rst(rst), .wp_n(wp_n), .busy(busy), .wel(wel),
    .op_wrsr(op_wrsr), .bp_wdata(sr_wdata[BP_LO+1:BP_LO]),
    .bp(bp), .rdy(rdy)
  );

  wprot_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_addr(chk_addr),
    .wel(wel), .bp(bp), .allow(wr_allow), .deny(wr_deny)
  );

  always_comb begin
    status          = '0;
    status[RDY_BIT] = rdy;
    status[WEL_BIT] = wel;
    status[BP_LO+1:BP_LO] = bp;
  end

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    status[SR_W-1:BP_LO+2] == '0); // R6
endmodule

// File: tb/sim_wprot_unit.sv
module sim_wprot_unit;
  logic clk = 0, rst = 1;
  logic cs_n = 1, wp_n = 1, busy = 0;
  logic op_wren = 0, op_wrdi = 0, op_wrsr = 0, op_write = 0;
  logic [7:0]  sr_wdata = 0;
  logic        chk_valid = 0;
  logic [15:0] chk_addr = 0;
  logic        wr_allow, wr_deny;
  logic [7:0]  status;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  wprot_unit #(.ADDR_W(16)) u0 (.*);

  // behavioural reference model
  int m_wel, m_bp, m_busy, m_allow, m_deny, m_pend, m_csq;

  function automatic int is_prot(int bp, int a);
    if (bp == 0) return 0;
    if (bp == 1) return (a >= 49152) ? 1 : 0;
    if (bp == 2) return (a >= 32768) ? 1 : 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_wel = 0; m_bp = 0; m_busy = 0; m_allow = 0; m_deny = 0;
      m_pend = 0; m_csq = 1;
    end else begin
      int ok, rise, nwel, nbp, npend;
      ok = (m_wel == 1 && is_prot(m_bp, int'(chk_addr)) == 0) ? 1 : 0;
      rise = (cs_n && m_csq == 0) ? 1 : 0;
      nbp = m_bp;
      if (op_wrsr && m_wel == 1 && wp_n) nbp = int'(sr_wdata[3:2]);
      nwel = m_wel;
      if (op_wrdi) nwel = 0;
      else if (op_wren) nwel = 1;
      else if (rise == 1 && m_pend == 1) nwel = 0;
      npend = (rise == 1) ? 0 : ((m_pend == 1 || op_write || op_wrsr) ? 1 : 0);
      m_allow = (chk_valid && ok == 1) ? 1 : 0;
      m_deny  = (chk_valid && ok == 0) ? 1 : 0;
      m_busy = busy ? 1 : 0;
      m_bp = nbp; m_wel = nwel; m_pend = npend; m_csq = cs_n ? 1 : 0;
    end
  end

  function automatic logic [7:0] m_status();
    return 8'(m_bp * 4 + m_wel * 2 + m_busy);
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      compared++;
      if (status !== m_status() || wr_allow !== m_allow[0] || wr_deny !== m_deny[0]) begin
        mismatched++;
        $display("FAIL %s: status=%h allow=%b deny=%b expected status=%h allow=%0d deny=%0d",
                 tag, status, wr_allow, wr_deny, m_status(), m_allow, m_deny);
      end
    end
  end

  task automatic check(string t, logic [7:0] got, logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  // one cycle: drive at negedge+1, strobes last one edge
  task automatic tick();
    @(negedge clk); #1;
    op_wren = 0; op_wrdi = 0; op_wrsr = 0; op_write = 0; chk_valid = 0;
  endtask

  task automatic wren(); op_wren = 1; tick(); endtask

  task automatic wrsr(logic [7:0] d);
    cs_n = 0; tick();
    op_wrsr = 1; sr_wdata = d; tick();
    cs_n = 1; tick();
  endtask

  task automatic probe(logic [15:0] a, logic exp_allow, string t);
    chk_valid = 1; chk_addr = a; tick();
    check(t, {7'd0, wr_allow}, {7'd0, exp_allow});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    tick();
    tag = "R1"; check("R1", status, 8'h00);
    check("R1", {6'd0, wr_allow, wr_deny}, 8'h00);
    tag = "R4"; probe(16'h0000, 0, "R4");
    tag = "R2"; wren(); check("R2", status, 8'h02);
    tag = "R5"; probe(16'h0000, 1, "R5"); probe(16'hFFFF, 1, "R5");
    tag = "R6"; wrsr(8'hF5); check("R6", status, 8'h04);
    wren(); tag = "R5";
    probe(16'hBFFF, 1, "R5"); probe(16'hC000, 0, "R5");
    wrsr(8'h08); wren(); check("R6", status, 8'h0A);
    probe(16'h7FFF, 1, "R5"); probe(16'h8000, 0, "R5");
    wrsr(8'h0C); wren(); probe(16'h0000, 0, "R5");
    tag = "R7";
    wp_n = 0; wren(); wrsr(8'h00); check("R7", status, 8'h0C);
    wp_n = 1; op_wrdi = 1; tick(); wrsr(8'h00); check("R7", status, 8'h0C);
    wren(); wrsr(8'h00); check("R7", status, 8'h00);
    wp_n = 0; wren(); probe(16'h1234, 1, "R7"); wp_n = 1;
    tag = "R3"; op_wren = 1; op_wrdi = 1; tick(); check("R3", status, 8'h00);
    tag = "R8"; wren(); cs_n = 0; tick(); cs_n = 1; tick();
    check("R8", status, 8'h02);
    cs_n = 0; tick(); op_write = 1; tick(); check("R8", status, 8'h02);
    cs_n = 1; tick(); check("R8", status, 8'h00);
    tag = "R9"; busy = 1; tick(); check("R9", status, 8'h01);
    busy = 0; tick(); check("R9", status, 8'h00);
    tag = "R4";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 15));
      op_wren = (r == 1); op_wrdi = (r == 2); op_wrsr = (r == 3);
      op_write = (r == 4); cs_n = ($urandom_range(0, 3) != 0);
      wp_n = ($urandom_range(0, 3) != 0); busy = $urandom_range(0, 1) == 1;
      sr_wdata = 8'($urandom); chk_valid = $urandom_range(0, 1) == 1;
      chk_addr = 16'($urandom);
      @(negedge clk); #1;
    end
    tick(); tick();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule